// File: doc/BRIEF.md
# Periodic Serial Target Message Transmitter

This block builds a fixed 16-bit status word from stored protection values and sends it over a two-wire synchronous link: a data line plus a clock that the block drives itself. The word holds a start marker, three trip flags, a pole-configuration flag, six current-sense flags, a flag that tells the receiver to ignore the target and mode content, and a two-bit release code. The field values come from storage outside the block and are held steady on its inputs.

Once reset ends, one message always goes out, whether or not a receiver is attached. After that, the word is sent again on a fixed period, but only while a presence alarm input is high. The period is counted in ticks of an external one-millisecond strobe, starting from the start of the previous message. When the alarm goes low, the period count is cleared. No further messages follow until the alarm rises again and a full period has passed. The field inputs are copied into the shift register at the moment a message starts, so they may change at any time without corrupting a message that is already on the line.

Top module: `target_msg_tx`

## Requirements
- R1: While `rst` is high, `ser_clk`, `ser_data` and `busy` are all 0.
- R2: Exactly one message starts on the first clock after reset is released, even with `alarm_in` low. While `alarm_in` stays low, no further message follows.
- R3: Word layout, low half. Bit 0 is always 1. Bits 1, 2 and 3 are `trip_tgt[0]`, `trip_tgt[1]` and `trip_tgt[2]` (phases A, B, C). Bit 4 is `three_pole` (1 = three-pole, 0 = single-pole). Bits 5 and 6 are always 1. Bit 7 is `load_ignore` (1 = receiver ignores target and mode bits).
- R4: Word layout, high half. Bits 8 to 13 are `cs_tgt[0]` to `cs_tgt[5]`, in the order A1, A2, B1, B2, C1, C2. Bit 14 is `rel_code[0]` and bit 15 is `rel_code[1]`.
- R5: The word is sent least-significant bit first. `ser_data` changes only while `ser_clk` is low, so it is stable at every rising edge of `ser_clk`, where the receiver samples it.
- R6: `ser_clk` is low whenever `busy` is low. Each bit spends `HALF_CYCLES` clocks with `ser_clk` low, then `HALF_CYCLES` clocks with it high. `busy` stays high for exactly 32×`HALF_CYCLES` clocks per message.
- R7: The field inputs are captured when a message starts. A change on them during a message affects only the next message.
- R8: While `alarm_in` stays high, consecutive messages start exactly `REPEAT_MS` tick periods apart. The period is counted from the start of the previous message.
- R9: A low `alarm_in` clears the period count and blocks a request. Dropping the alarm in the cycle where the period expires produces no message. After the alarm rises again, the next message waits a full `REPEAT_MS` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_tgt | input | 3 | Trip flags for phases A, B, C (bit 0 = A) |
| three_pole | input | 1 | Pole configuration: 1 = three-pole, 0 = single-pole |
| load_ignore | input | 1 | 1 tells the receiver to ignore target and mode bits |
| cs_tgt | input | 6 | Current-sense flags A1, A2, B1, B2, C1, C2 (bit 0 = A1) |
| rel_code | input | 2 | Trip release code |
| alarm_in | input | 1 | Presence alarm level that enables repeats |
| ms_tick | input | 1 | One-clock strobe once per millisecond |
| ser_data | output | 1 | Serial data, LSB first |
| ser_clk | output | 1 | Serial clock; receiver samples on its rising edge |
| busy | output | 1 | High while a message is being shifted out |

## Verification
Two of the block's functions can meet in the same cycle: the repeat timer reaching its full count, and the alarm level deciding whether that expiry may start a message. The bench measures when the previous message started. It then lowers `alarm_in` one clock before the next start would fall due, which is after the final tick has already brought the count to full. The bench then judges the result at the ports: `busy` must stay low for several whole periods, and when the alarm rises again, the next start must come only after a fresh full count.

// File: rtl/tgt_msg_pkg.sv
`timescale 1ns/1ps
package tgt_msg_pkg;

    localparam int WORD_W = 16;
    localparam int IDX_W  = $clog2(WORD_W);

    typedef struct packed {
        logic [1:0] rel;
        logic [5:0] cs;
        logic       load_ign;
        logic       three_pole;
        logic [2:0] trip;
    } tgt_fields_t;

    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_LOW  = 2'd1,
        SER_HIGH = 2'd2
    } ser_state_e;

    // Fixed layout: start marker at the bottom, two constant ones at bits 5 and 6.
    function automatic logic [WORD_W-1:0] pack_word(input tgt_fields_t f);
        pack_word = {f.rel, f.cs, f.load_ign, 2'b11, f.three_pole, f.trip, 1'b1};
    endfunction

endpackage

// File: rtl/tgt_repeat_timer.sv
`timescale 1ns/1ps
module tgt_repeat_timer #(
    parameter int REPEAT_MS = 750
) (
    input  logic clk,
    input  logic rst,
    input  logic alarm_in,
    input  logic ms_tick,
    input  logic start,
    output logic send_req
);
    localparam int CNT_W = $clog2(REPEAT_MS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(REPEAT_MS);

    logic             first_pend;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_pend <= 1'b1;
            cnt        <= '0;
        end else if (start) begin
            first_pend <= 1'b0;
            cnt        <= '0;
        end else if (!alarm_in) begin
            cnt <= '0;
        end else if (ms_tick && cnt != FULL) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign send_req = first_pend | (alarm_in & (cnt == FULL));

    // R8: count saturates at the period length
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);

    // R9: a low alarm leaves the count empty on the next cycle
    a_r9_clear_on_low: assert property (@(posedge clk) disable iff (rst)
        $past(!alarm_in) |-> cnt == '0);

endmodule

// File: rtl/tgt_serializer.sv
`timescale 1ns/1ps
module tgt_serializer
    import tgt_msg_pkg::*;
#(
    parameter int HALF_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              send_req,
    input  logic [WORD_W-1:0] word,
    output logic              start,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              busy
);
    localparam int PH_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(HALF_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

    ser_state_e        state;
    logic [WORD_W-1:0] shreg;
    logic [IDX_W-1:0]  bit_idx;
    logic [PH_W-1:0]   ph;

    assign busy  = (state != SER_IDLE);
    assign start = send_req & (state == SER_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SER_IDLE;
            shreg    <= '0;
            bit_idx  <= '0;
            ph       <= '0;
            ser_data <= 1'b0;
            ser_clk  <= 1'b0;
        end else begin
            unique case (state)
                SER_IDLE: begin
                    if (send_req) begin
                        shreg    <= word;
                        ser_data <= word[0];
                        bit_idx  <= '0;
                        ph       <= '0;
                        state    <= SER_LOW;
                    end
                end
                SER_LOW: begin
                    if (ph == PH_LAST) begin
                        ph      <= '0;
                        ser_clk <= 1'b1;
                        state   <= SER_HIGH;
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                SER_HIGH: begin
                    if (ph == PH_LAST) begin
                        ph      <= '0;
                        ser_clk <= 1'b0;
                        if (bit_idx == IDX_LAST) begin
                            ser_data <= 1'b0;
                            state    <= SER_IDLE;
                        end else begin
                            bit_idx  <= bit_idx + 1'b1;
                            shreg    <= {1'b0, shreg[WORD_W-1:1]};
                            ser_data <= shreg[1];
                            state    <= SER_LOW;
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                default: state <= SER_IDLE;
            endcase
        end
    end

    // R3: the first bit on the line is the start marker
    a_r3_start_bit: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ser_data);

    // R6: clock parks low between messages
    a_r6_clk_idle_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ser_clk);

    // R5: data holds while the clock is high
    a_r5_data_stable_high: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

endmodule

// File: rtl/target_msg_tx.sv
`timescale 1ns/1ps
module target_msg_tx
    import tgt_msg_pkg::*;
#(
    parameter int HALF_CYCLES = 4,
    parameter int REPEAT_MS   = 750
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] trip_tgt,
    input  logic       three_pole,
    input  logic       load_ignore,
    input  logic [5:0] cs_tgt,
    input  logic [1:0] rel_code,
    input  logic       alarm_in,
    input  logic       ms_tick,
    output logic       ser_data,
    output logic       ser_clk,
    output logic       busy
);
    tgt_fields_t       fields;
    logic [WORD_W-1:0] word;
    logic              send_req;
    logic              start;

    always_comb begin
        fields.trip       = trip_tgt;
        fields.three_pole = three_pole;
        fields.load_ign   = load_ignore;
        fields.cs         = cs_tgt;
        fields.rel        = rel_code;
        word              = pack_word(fields);
    end

    tgt_repeat_timer #(.REPEAT_MS(REPEAT_MS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .alarm_in (alarm_in),
        .ms_tick  (ms_tick),
        .start    (start),
        .send_req (send_req)
    );

    tgt_serializer #(.HALF_CYCLES(HALF_CYCLES)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .send_req (send_req),
        .word     (word),
        .start    (start),
        .ser_data (ser_data),
        .ser_clk  (ser_clk),
        .busy     (busy)
    );

    // R1: outputs quiet right after a reset cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!ser_clk && !busy));

endmodule

// File: tb/target_msg_tx_test.sv
`timescale 1ns/1ps
module target_msg_tx_test;
    localparam int HALF    = 2;
    localparam int REP     = 8;
    localparam int T       = 16;
    localparam int MSG_LEN = 32 * HALF;
    localparam int PERIOD  = REP * T;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] trip_tgt = '0;
    logic       three_pole = 1'b0;
    logic       load_ignore = 1'b0;
    logic [5:0] cs_tgt = '0;
    logic [1:0] rel_code = '0;
    logic       alarm_in = 1'b0;
    logic       ms_tick = 1'b0;
    logic       ser_data, ser_clk, busy;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int tcnt     = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (tcnt == T - 1) begin
            tcnt    <= 0;
            ms_tick <= 1'b1;
        end else begin
            tcnt    <= tcnt + 1;
            ms_tick <= 1'b0;
        end
    end

    target_msg_tx #(.HALF_CYCLES(HALF), .REPEAT_MS(REP)) uut (
        .clk(clk), .rst(rst), .trip_tgt(trip_tgt), .three_pole(three_pole),
        .load_ignore(load_ignore), .cs_tgt(cs_tgt), .rel_code(rel_code),
        .alarm_in(alarm_in), .ms_tick(ms_tick),
        .ser_data(ser_data), .ser_clk(ser_clk), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    function automatic logic [15:0] pat(input int k);
        pat = 16'((k * 40503 + 4660) & 16'hFFFF);
    endfunction

    task automatic set_pat(input int k);
        logic [15:0] p;
        p = pat(k);
        trip_tgt    = p[2:0];
        three_pole  = p[3];
        load_ignore = p[4];
        cs_tgt      = p[10:5];
        rel_code    = p[12:11];
    endtask

    // Expected word from R3/R4, computed arithmetically
    function automatic int exp_word();
        int w;
        w = 1 + 2 * trip_tgt + 16 * three_pole + 32 + 64 + 128 * load_ignore
            + 256 * cs_tgt + 16384 * rel_code;
        return w;
    endfunction

    // Monitor: observes outputs at the falling edge of clk
    int   start_cnt  = 0;
    int   last_start = 0;
    int   rise_cyc   = 0;
    int   exp_w      = 0;
    int   got_w      = 0;
    int   nbits      = 0;
    bit   have_prev  = 1'b0;
    bit   alarm_gap  = 1'b1;
    logic prev_busy  = 1'b0;
    logic prev_sclk  = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!alarm_in) alarm_gap = 1'b1;
            if (busy && !prev_busy) begin
                // R8: steady-state repeat interval
                if (have_prev && !alarm_gap)
                    check(cyc - last_start == PERIOD, "R8 interval", cyc - last_start, PERIOD);
                start_cnt++;
                last_start = cyc;
                rise_cyc   = cyc;
                have_prev  = 1'b1;
                alarm_gap  = 1'b0;
                exp_w      = exp_word();
                got_w      = 0;
                nbits      = 0;
            end
            if (ser_clk && !prev_sclk) begin
                if (nbits < 16) got_w = got_w | (int'(ser_data) << nbits);
                nbits++;
                if (nbits == 16) begin
                    // R3 R4 R5 R7: word content, LSB first, captured at start
                    check(got_w[7:0] == exp_w[7:0], "R3 low byte", got_w[7:0], exp_w[7:0]);
                    check(got_w[15:8] == exp_w[15:8], "R4 high byte", got_w[15:8], exp_w[15:8]);
                end
            end
            if (!busy && prev_busy) begin
                // R6: message length and idle clock
                check(cyc - rise_cyc == MSG_LEN, "R6 busy length", cyc - rise_cyc, MSG_LEN);
                check(!ser_clk && nbits == 16, "R6 idle clk and bit count", nbits, 16);
            end
        end
        prev_busy = busy;
        prev_sclk = ser_clk;
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_start(input int target);
        while (start_cnt < target) step(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        int a_cyc;
        int n0;
        set_pat(0);
        step(5);
        // R1: quiet during reset
        check(!ser_clk && !ser_data && !busy, "R1 reset outputs",
              {ser_clk, ser_data, busy}, 0);
        rst = 1'b0;
        step(3);
        // R2: first message without alarm
        check(busy == 1'b1, "R2 first message started", busy, 1);
        step(MSG_LEN + 4 * PERIOD);
        check(start_cnt == 1, "R2 no repeat while alarm low", start_cnt, 1);

        // R8 R7: repeats with fields changing mid-message
        set_pat(1);
        alarm_in = 1'b1;
        a_cyc = cyc;
        for (int k = 2; k <= 60; k++) begin
            wait_start(k);
            if (k == 2)
                check(last_start - a_cyc > (REP - 1) * T && last_start - a_cyc <= REP * T + 2,
                      "R8 first repeat delay", last_start - a_cyc, REP * T);
            set_pat(k);
        end

        // R9: alarm drops on the expiry cycle
        n0 = start_cnt;
        while (cyc < last_start + PERIOD - 1) step(1);
        alarm_in = 1'b0;
        step(4 * PERIOD);
        check(start_cnt == n0, "R9 no message after drop at expiry", start_cnt, n0);

        // R9: re-arm waits a full period
        alarm_in = 1'b1;
        a_cyc = cyc;
        wait_start(n0 + 1);
        check(last_start - a_cyc > (REP - 1) * T && last_start - a_cyc <= REP * T + 2,
              "R9 full period after re-arm", last_start - a_cyc, REP * T);
        set_pat(77);
        wait_start(n0 + 3);

        // R2 R9: alarm low stops repeats
        step(MSG_LEN + 2);
        alarm_in = 1'b0;
        n0 = start_cnt;
        step(3 * PERIOD);
        check(start_cnt == n0, "R9 stop after alarm low", start_cnt, n0);
        check(!busy && !ser_clk, "R6 idle at end", {busy, ser_clk}, 0);
        finish_run();
    end
endmodule